// File: doc/BRIEF.md
# Microcoded Instruction Step Sequencer

This block is the control unit of a small accumulator machine whose instructions are all one byte wide. It holds the instruction register, a micro-step counter and the carry and zero flags. On every clock the pair (opcode, step) selects one control word. That word drives three things: the register load strobes, the choice of what drives the shared data bus, and which operand feeds the ALU adder. The surrounding datapath (instruction pointer, accumulator, temporary operand register, adder and memory) sits outside the block and obeys these strobes.

The machine has no separate program-counter incrementer. Each instruction starts with the same three steps. The first fetches the opcode at the address held by the instruction pointer. The second preloads the temporary register with the constant one. The third writes the adder result back into the instruction pointer. Skips, relative jumps and stepping over an inline operand byte use the same path. They preload the temporary register with a flag-derived 0/1 or with a signed offset, then add it to the instruction pointer. Every control word carries an end bit that returns the step counter to zero, so the next instruction's fetch always happens at step 0.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low, the step counter, instruction register, carry and zero all read zero and every strobe is inactive (`dsrc_o` = 0). Release of `rst_n` passes through a two-flop synchroniser before it takes effect.
- R2: At step 0 the block asserts `addr_ip_o`, `dsrc_o`=1 (memory) and `ld_ir_o`, and the IR captures `bus_lo_i`. At step 1 it asserts `dsrc_o`=3 (constant one) with `ld_b_o`. At step 2 it asserts `alu_src_o`=0 (instruction pointer), `dsrc_o`=2 (adder) and `ld_ip_o`. The instruction pointer is only ever loaded from the adder, and the IR holds its value at every other step.
- R3: The step counter advances by one on each clock. After a clock in which `end_o` is high it returns to 0, and a fetch follows.
- R4: Opcode 0x01 sets carry and opcode 0x02 clears it. Each takes 3 clocks.
- R5: Opcodes 0x04 to 0x07 are skips. Bit 1 picks the flag (0 carry, 1 zero) and bit 0 set means skip when the flag is clear. At step 3 `cond_o` (1 when the skip condition holds) is driven with `dsrc_o`=4 into the temporary register. At step 4 the adder result loads the instruction pointer. Each takes 5 clocks.
- R6: Opcode 0x10 is a relative jump. The offset byte that follows the opcode is read as signed, and the new pointer equals the offset byte's own address plus the offset. It takes 5 clocks.
- R7: Opcode 0x20 loads the following byte into the accumulator and moves the pointer past it. It takes 6 clocks.
- R8: Opcode 0x21 adds the following byte to the accumulator. Carry takes `alu_c_i` (carry out of bit 7) and zero takes `alu_z_i` (8-bit result is zero). Flags change only under 0x01, 0x02 and 0x21. It takes 7 clocks.
- R9: Any other opcode (for example 0x3F) takes 3 clocks, moves the pointer on by one and changes neither the flags nor the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_lo_i | input | 8 | Low byte of the shared data bus |
| alu_c_i | input | 1 | Carry out of bit 7 of the adder |
| alu_z_i | input | 1 | Low byte of the adder result is zero |
| ir_o | output | 8 | Instruction register |
| step_o | output | STEP_W | Current micro-step |
| addr_ip_o | output | 1 | Instruction pointer drives the address bus |
| alu_src_o | output | 1 | Adder operand: 0 instruction pointer, 1 accumulator |
| dsrc_o | output | 3 | Data bus source: 0 none, 1 memory, 2 adder, 3 one, 4 condition |
| ld_ir_o | output | 1 | Instruction register load strobe |
| ld_ip_o | output | 1 | Instruction pointer load strobe |
| ld_a_o | output | 1 | Accumulator load strobe |
| ld_b_o | output | 1 | Temporary register load strobe |
| cond_o | output | 1 | Skip condition value for the selected flag |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| end_o | output | 1 | Last step of the current instruction |

## Verification
The assertions assume that `alu_c_i` and `alu_z_i` describe the 8-bit sum of accumulator and temporary register on the clock where the flags load. They also assume that `bus_lo_i` carries the byte the memory returns for the current pointer whenever memory is the selected source. The bench meets both assumptions by modelling the datapath from the block's own strobes. It runs a fixed program whose pointer trace was worked out by hand: both polarities of both skip flags, forward and backward jumps, an 8-bit overflow into carry and zero, a skipped flag write, and an unassigned opcode. A scoreboard compares each fetch address, flag pair, accumulator value and instruction length against that trace.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int IW = 8;

  typedef enum logic [2:0] {
    DS_NONE = 3'd0,
    DS_MEM  = 3'd1,
    DS_ALU  = 3'd2,
    DS_ONE  = 3'd3,
    DS_COND = 3'd4
  } dsrc_e;

  typedef struct packed {
    logic  addr_ip;
    logic  alu_a;
    dsrc_e dsrc;
    logic  ld_ir;
    logic  ld_ip;
    logic  ld_a;
    logic  ld_b;
    logic  ld_flg;
    logic  c_set;
    logic  c_clr;
    logic  done;
  } ucw_t;

  localparam logic [IW-1:0] OP_SETC = 8'h01;
  localparam logic [IW-1:0] OP_CLRC = 8'h02;
  localparam logic [IW-1:0] OP_JREL = 8'h10;
  localparam logic [IW-1:0] OP_LDI  = 8'h20;
  localparam logic [IW-1:0] OP_ADDI = 8'h21;
  localparam logic [IW-3:0] OP_SKIP_HI = 6'b000001;
endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/useq_step_ctr.sv
module useq_step_ctr #(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  output logic [STEP_W-1:0] step_q
);
  logic [STEP_W-1:0] step_d;

  always_comb begin
    if (done) step_d = '0;
    else      step_d = step_q + STEP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end
endmodule

// File: rtl/useq_urom.sv
module useq_urom
  import useq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic [IW-1:0]     op,
  input  logic [STEP_W-1:0] step,
  output ucw_t              cw
);
  logic is_skip;
  assign is_skip = (op[IW-1:2] == OP_SKIP_HI);

  always_comb begin
    cw = '0;
    if (step == STEP_W'(0)) begin
      cw.addr_ip = 1'b1;
      cw.dsrc    = DS_MEM;
      cw.ld_ir   = 1'b1;
    end else if (step == STEP_W'(1)) begin
      cw.dsrc = DS_ONE;
      cw.ld_b = 1'b1;
    end else if (step == STEP_W'(2)) begin
      cw.dsrc  = DS_ALU;
      cw.ld_ip = 1'b1;
      if (!(is_skip || op == OP_JREL || op == OP_LDI || op == OP_ADDI)) begin
        cw.done  = 1'b1;
        cw.c_set = (op == OP_SETC);
        cw.c_clr = (op == OP_CLRC);
      end
    end else if (is_skip) begin
      if (step == STEP_W'(3)) begin
        cw.dsrc = DS_COND;
        cw.ld_b = 1'b1;
      end else begin
        cw.dsrc  = DS_ALU;
        cw.ld_ip = 1'b1;
        cw.done  = 1'b1;
      end
    end else if (op == OP_JREL) begin
      if (step == STEP_W'(3)) begin
        cw.addr_ip = 1'b1;
        cw.dsrc    = DS_MEM;
        cw.ld_b    = 1'b1;
      end else begin
        cw.dsrc  = DS_ALU;
        cw.ld_ip = 1'b1;
        cw.done  = 1'b1;
      end
    end else if (op == OP_LDI) begin
      if (step == STEP_W'(3)) begin
        cw.addr_ip = 1'b1;
        cw.dsrc    = DS_MEM;
        cw.ld_a    = 1'b1;
      end else if (step == STEP_W'(4)) begin
        cw.dsrc = DS_ONE;
        cw.ld_b = 1'b1;
      end else begin
        cw.dsrc  = DS_ALU;
        cw.ld_ip = 1'b1;
        cw.done  = 1'b1;
      end
    end else if (op == OP_ADDI) begin
      if (step == STEP_W'(3)) begin
        cw.addr_ip = 1'b1;
        cw.dsrc    = DS_MEM;
        cw.ld_b    = 1'b1;
      end else if (step == STEP_W'(4)) begin
        cw.alu_a  = 1'b1;
        cw.dsrc   = DS_ALU;
        cw.ld_a   = 1'b1;
        cw.ld_flg = 1'b1;
      end else if (step == STEP_W'(5)) begin
        cw.dsrc = DS_ONE;
        cw.ld_b = 1'b1;
      end else begin
        cw.dsrc  = DS_ALU;
        cw.ld_ip = 1'b1;
        cw.done  = 1'b1;
      end
    end else begin
      cw.done = 1'b1;
    end
  end
endmodule

// File: rtl/useq_flags.sv
module useq_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic       set_c,
  input  logic       clr_c,
  input  logic       alu_c,
  input  logic       alu_z,
  input  logic [1:0] sel,
  output logic       c_q,
  output logic       z_q,
  output logic       cond
);
  logic c_d;
  logic z_d;

  always_comb begin
    c_d = c_q;
    z_d = z_q;
    if (set_c)      c_d = 1'b1;
    else if (clr_c) c_d = 1'b0;
    else if (ld) begin
      c_d = alu_c;
      z_d = alu_z;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
    end else begin
      c_q <= c_d;
      z_q <= z_d;
    end
  end

  assign cond = (sel[1] ? z_q : c_q) ^ sel[0];
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IW-1:0]     bus_lo_i,
  input  logic              alu_c_i,
  input  logic              alu_z_i,
  output logic [IW-1:0]     ir_o,
  output logic [STEP_W-1:0] step_o,
  output logic              addr_ip_o,
  output logic              alu_src_o,
  output logic [2:0]        dsrc_o,
  output logic              ld_ir_o,
  output logic              ld_ip_o,
  output logic              ld_a_o,
  output logic              ld_b_o,
  output logic              cond_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic              end_o
);
  logic              rst_s_n;
  logic [STEP_W-1:0] step_q;
  logic [IW-1:0]     ir_q;
  logic [IW-1:0]     ir_d;
  ucw_t              cw_raw;
  ucw_t              cw;

  useq_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .arst_n(rst_n),
    .srst_n(rst_s_n)
  );

  useq_urom #(.STEP_W(STEP_W)) u_rom (
    .op  (ir_q),
    .step(step_q),
    .cw  (cw_raw)
  );

  always_comb cw = rst_s_n ? cw_raw : '0;

  useq_step_ctr #(.STEP_W(STEP_W)) u_step (
    .clk   (clk),
    .rst_n (rst_s_n),
    .done  (cw.done),
    .step_q(step_q)
  );

  always_comb ir_d = cw.ld_ir ? bus_lo_i : ir_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) ir_q <= '0;
    else          ir_q <= ir_d;
  end

  useq_flags u_flg (
    .clk  (clk),
    .rst_n(rst_s_n),
    .ld   (cw.ld_flg),
    .set_c(cw.c_set),
    .clr_c(cw.c_clr),
    .alu_c(alu_c_i),
    .alu_z(alu_z_i),
    .sel  (ir_q[1:0]),
    .c_q  (carry_o),
    .z_q  (zero_o),
    .cond (cond_o)
  );

  assign ir_o      = ir_q;
  assign step_o    = step_q;
  assign addr_ip_o = cw.addr_ip;
  assign alu_src_o = cw.alu_a;
  assign dsrc_o    = cw.dsrc;
  assign ld_ir_o   = cw.ld_ir;
  assign ld_ip_o   = cw.ld_ip;
  assign ld_a_o    = cw.ld_a;
  assign ld_b_o    = cw.ld_b;
  assign end_o     = cw.done;
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk #(
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              srst_n,
  input logic [7:0]        ir_o,
  input logic [STEP_W-1:0] step_o,
  input logic              addr_ip_o,
  input logic [2:0]        dsrc_o,
  input logic              ld_ir_o,
  input logic              ld_ip_o,
  input logic              carry_o,
  input logic              zero_o,
  input logic              end_o
);
  AST_END_RESTART: assert property (@(posedge clk) disable iff (!srst_n)
    end_o |=> (step_o == '0)); // R3
  AST_END_FETCH: assert property (@(posedge clk) disable iff (!srst_n)
    end_o |=> ld_ir_o); // R3
  AST_STEP_ADV: assert property (@(posedge clk) disable iff (!srst_n)
    !end_o |=> (step_o == $past(step_o) + STEP_W'(1))); // R3
  AST_FETCH_STEP0: assert property (@(posedge clk) disable iff (!srst_n)
    ld_ir_o |-> (step_o == '0 && addr_ip_o && dsrc_o == 3'd1)); // R2
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    !ld_ir_o |=> $stable(ir_o)); // R2
  AST_IP_FROM_ADDER: assert property (@(posedge clk) disable iff (!srst_n)
    ld_ip_o |-> (dsrc_o == 3'd2)); // R2
  AST_SETC: assert property (@(posedge clk) disable iff (!srst_n)
    (end_o && ir_o == 8'h01) |=> carry_o); // R4
  AST_CLRC: assert property (@(posedge clk) disable iff (!srst_n)
    (end_o && ir_o == 8'h02) |=> !carry_o); // R4
  AST_FLAG_OWNER: assert property (@(posedge clk) disable iff (!srst_n)
    !$stable({carry_o, zero_o}) |->
      ($past(ir_o) == 8'h01 || $past(ir_o) == 8'h02 || $past(ir_o) == 8'h21)); // R8
endmodule

bind useq_ctrl useq_ctrl_chk #(.STEP_W(STEP_W)) chk_i (
  .clk      (clk),
  .srst_n   (rst_s_n),
  .ir_o     (ir_o),
  .step_o   (step_o),
  .addr_ip_o(addr_ip_o),
  .dsrc_o   (dsrc_o),
  .ld_ir_o  (ld_ir_o),
  .ld_ip_o  (ld_ip_o),
  .carry_o  (carry_o),
  .zero_o   (zero_o),
  .end_o    (end_o)
);

// File: tb/useq_ctrl_tb_top.sv
module useq_ctrl_tb_top;
  localparam int STEP_W = 3;

  logic clk;
  logic rst_n;
  logic [7:0] bus_lo;
  logic alu_c, alu_z;
  logic [7:0] ir;
  logic [STEP_W-1:0] step;
  logic addr_ip, alu_src, ld_ir, ld_ip, ld_a, ld_b, cond, carry, zero, done_w;
  logic [2:0] dsrc;

  useq_ctrl #(.STEP_W(STEP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_lo_i(bus_lo), .alu_c_i(alu_c), .alu_z_i(alu_z),
    .ir_o(ir), .step_o(step), .addr_ip_o(addr_ip), .alu_src_o(alu_src),
    .dsrc_o(dsrc), .ld_ir_o(ld_ir), .ld_ip_o(ld_ip), .ld_a_o(ld_a), .ld_b_o(ld_b),
    .cond_o(cond), .carry_o(carry), .zero_o(zero), .end_o(done_w)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // datapath model
  logic [7:0]  mem [256];
  logic [15:0] ip;
  logic [7:0]  a_r, b_r;
  logic [15:0] alu_out, bus;
  logic [8:0]  sum8;

  always_comb begin
    alu_out = (alu_src ? {{8{a_r[7]}}, a_r} : ip) + {{8{b_r[7]}}, b_r};
    sum8    = {1'b0, a_r} + {1'b0, b_r};
    alu_c   = sum8[8];
    alu_z   = (sum8[7:0] == 8'h00);
    case (dsrc)
      3'd1:    bus = {8'h00, addr_ip ? mem[ip[7:0]] : 8'hFF};
      3'd2:    bus = alu_out;
      3'd3:    bus = 16'h0001;
      3'd4:    bus = {15'b0, cond};
      default: bus = 16'hFFFF;
    endcase
    bus_lo = bus[7:0];
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip <= '0; a_r <= '0; b_r <= '0;
    end else begin
      if (ld_ip) ip <= bus;
      if (ld_a)  a_r <= bus[7:0];
      if (ld_b)  b_r <= bus[7:0];
    end
  end

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    int addr; int len; bit c; bit z; int a; string tag;
  } item_t;
  item_t sbq[$];

  task automatic push_exp(input int addr, input int len, input bit c, input bit z,
                          input int a, input string tag);
    item_t it;
    it.addr = addr; it.len = len; it.c = c; it.z = z; it.a = a; it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor
  item_t prev;
  bit have_prev = 0;
  int cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ld_ir) begin
        if (have_prev)
          chk(cnt == prev.len, prev.tag, $sformatf("R3 length of op at %0d", prev.addr),
              cnt, prev.len);
        if (sbq.size() > 0) begin
          item_t it;
          it = sbq.pop_front();
          chk(ip == 16'(it.addr), it.tag, "R2 fetch address", ip, it.addr);
          chk(carry == it.c, it.tag, $sformatf("carry at %0d", it.addr), carry, it.c);
          chk(zero == it.z, it.tag, $sformatf("zero at %0d", it.addr), zero, it.z);
          chk(a_r == 8'(it.a), it.tag, $sformatf("accumulator at %0d", it.addr), a_r, it.a);
          prev = it;
          have_prev = 1;
        end else begin
          have_prev = 0;
        end
        cnt = 1;
      end else begin
        cnt++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[0]=8'h01; mem[1]=8'h04; mem[2]=8'h02; mem[3]=8'h05; mem[4]=8'h02;
    mem[5]=8'h20; mem[6]=8'hFF; mem[7]=8'h21; mem[8]=8'h01; mem[9]=8'h06;
    mem[10]=8'h02; mem[11]=8'h07; mem[12]=8'h3F; mem[13]=8'h10; mem[14]=8'h04;
    mem[15]=8'h00; mem[16]=8'h10; mem[17]=8'h05; mem[18]=8'h10; mem[19]=8'hFC;
    mem[20]=8'h02; mem[21]=8'h02; mem[22]=8'h02; mem[23]=8'h04; mem[24]=8'h05;
    mem[25]=8'h01; mem[26]=8'h21; mem[27]=8'h01; mem[28]=8'h07; mem[29]=8'h01;
    mem[30]=8'h06;

    // expected trace: address, own length, flags and A on arrival, tags
    push_exp(0,  3, 0, 0, 8'h00, "R1/R4");
    push_exp(1,  5, 1, 0, 8'h00, "R4/R5");
    push_exp(3,  5, 1, 0, 8'h00, "R5");
    push_exp(4,  3, 1, 0, 8'h00, "R5/R4");
    push_exp(5,  6, 0, 0, 8'h00, "R4/R7");
    push_exp(7,  7, 0, 0, 8'hFF, "R7/R8");
    push_exp(9,  5, 1, 1, 8'h00, "R8/R5");
    push_exp(11, 5, 1, 1, 8'h00, "R5");
    push_exp(12, 3, 1, 1, 8'h00, "R5/R9");
    push_exp(13, 5, 1, 1, 8'h00, "R9/R6");
    push_exp(18, 5, 1, 1, 8'h00, "R6");
    push_exp(15, 3, 1, 1, 8'h00, "R6/R9");
    push_exp(16, 5, 1, 1, 8'h00, "R9/R6");
    push_exp(22, 3, 1, 1, 8'h00, "R6/R4");
    push_exp(23, 5, 0, 1, 8'h00, "R4/R5");
    push_exp(24, 5, 0, 1, 8'h00, "R5");
    push_exp(26, 7, 0, 1, 8'h00, "R5/R8");
    push_exp(28, 5, 0, 0, 8'h01, "R8/R5");
    push_exp(30, 5, 0, 0, 8'h01, "R5");
    push_exp(31, 3, 0, 0, 8'h01, "R5/R9");
    push_exp(32, 3, 0, 0, 8'h01, "R9");
    push_exp(33, 3, 0, 0, 8'h01, "R9");

    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(step == '0, "R1", "step in reset", step, 0);
    chk(ir == 8'h00, "R1", "IR in reset", ir, 0);
    chk(carry == 1'b0, "R1", "carry in reset", carry, 0);
    chk(zero == 1'b0, "R1", "zero in reset", zero, 0);
    chk(ld_ir == 1'b0 && dsrc == 3'd0, "R1", "strobes in reset", {ld_ir, dsrc}, 0);
    rst_n = 1'b1;

    wait (sbq.size() == 0);
    repeat (10) @(posedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule